// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block steers every access that falls in the upper part of the first megabyte of physical address space. For each 20-bit access address and read/write flag, a combinational decode gives a target code. The code says whether the access goes to system DRAM, is forwarded to the expansion bus side, or is discarded as a write to read-only memory. Addresses below 0xA0000 always go to DRAM.

The window from 0xC0000 to 0xEFFFF is divided into twelve 16 KB segments, and the 64 KB block at 0xF0000 is one more region. Each has its own 2-bit attribute, held in byte-wide configuration registers. The 128 KB video window at 0xA0000 has no attribute. It is opened to DRAM by a control register, either unconditionally or only while the system-management-mode input is high. Software programs the registers through a byte write/read port. A register write changes the decode from the next clock cycle. A change on the mode input changes it in the same cycle.

Top module: `lmr_decoder`

## Requirements
- R1: After reset the attribute registers (offsets 0x59 and 0x5A..0x5F) read 0x00 and the control register (offset 0x72) reads 0x02.
- R2: A write to offset 0x59, 0x5A..0x5F or 0x72 stores the full byte, which reads back through cfg_rdata. A write to any other offset is ignored, and any other offset reads 0x00.
- R3: Addresses 0xF0000..0xFFFFF use the attribute in bits [5:4] of offset 0x59.
- R4: Segment i (0..11) covers 0xC0000 + i*0x4000 up to 16 KB. Its attribute is bits [1:0] of the low nibble of offset 0x5A + i/2 when i is even, and bits [5:4] of that byte when i is odd.
- R5: Route codes: 0 = DRAM, 1 = forward, 2 = discard. Code 3 never appears. Attribute 3 routes reads and writes to DRAM.
- R6: Attribute 0 forwards both reads and writes.
- R7: Attribute 1 routes reads to DRAM and discards writes. A read is never discarded.
- R8: Attribute 2 forwards reads and routes writes to DRAM.
- R9: Addresses 0xA0000..0xBFFFF route to DRAM for reads and writes whenever bit 6 of offset 0x72 is set.
- R10: If bit 6 of offset 0x72 is clear, the video window routes to DRAM when smm_active is high and bit 3 of offset 0x72 is set. Otherwise it is forwarded.
- R11: Addresses below 0xA0000 always route to DRAM.
- R12: A register write affects the route from the cycle after the write edge. A change of smm_active affects it in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration offset for write and read |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration byte at cfg_addr (combinational) |
| smm_active | input | 1 | System-management-mode state |
| acc_addr | input | 20 | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read |
| route | output | 2 | Target code: 0 DRAM, 1 forward, 2 discard |

## Verification
Four register patterns rotate the attribute across every segment, so each of the thirteen regions is decoded under all four attributes, for both reads and writes, at its first and last address. Unused nibble bits in the register bytes are set to ones, so a decode that reads the wrong bits or the wrong nibble gives a wrong code. The video window is swept over all eight combinations of the two control bits and the mode input, which separates the unconditional opening from the mode-gated one. Writes to neighbouring unused offsets, readbacks and addresses just below the window complete the picture.

// File: rtl/lmr_pkg.sv
// Shared types for the legacy memory region decoder.
package lmr_pkg;
    // Target selected for one access.
    typedef enum logic [1:0] {
        ROUTE_DRAM = 2'b00,
        ROUTE_FWD  = 2'b01,
        ROUTE_DROP = 2'b10
    } route_e;

    // Which part of the legacy window an address falls in.
    typedef enum logic [1:0] {
        REGION_LOW   = 2'b00,
        REGION_VIDEO = 2'b01,
        REGION_SEG   = 2'b10,
        REGION_HIGH  = 2'b11
    } region_e;

    // Attribute codes.
    localparam logic [1:0] ATTR_OFF = 2'd0;
    localparam logic [1:0] ATTR_RO  = 2'd1;
    localparam logic [1:0] ATTR_WO  = 2'd2;
    localparam logic [1:0] ATTR_RW  = 2'd3;
endpackage

// File: rtl/lmr_cfg_regs.sv
// Configuration register file: one high-region byte, NUM_SEG/2 segment
// bytes holding two nibble attributes each, and a video control byte.
// Assumes one byte write per cycle; reads are combinational.
module lmr_cfg_regs #(
    parameter int unsigned NUM_SEG   = 12,
    parameter logic [7:0]  HI_OFF    = 8'h59,
    parameter logic [7:0]  SEG_OFF   = 8'h5A,
    parameter logic [7:0]  CTL_OFF   = 8'h72,
    parameter logic [7:0]  CTL_RST   = 8'h02,
    parameter int unsigned HI_LSB    = 4,
    parameter int unsigned OPEN_BIT  = 6,
    parameter int unsigned SMM_BIT   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [7:0]             addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output logic [1:0]             hi_attr,
    output logic [NUM_SEG*2-1:0]   seg_attr,
    output logic                   ctl_open,
    output logic                   ctl_smm
);
    localparam int unsigned NUM_BYTES = NUM_SEG / 2;

    logic [7:0]             hi_q;
    logic [7:0]             ctl_q;
    logic [NUM_BYTES*8-1:0] seg_q;

    // High-region attribute byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hi_q <= 8'h00;
        else if (we && addr == HI_OFF) hi_q <= wdata;
    end

    // Video window control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ctl_q <= CTL_RST;
        else if (we && addr == CTL_OFF) ctl_q <= wdata;
    end

    generate
        for (genvar g = 0; g < NUM_BYTES; g++) begin : g_seg
            localparam logic [7:0] MY_OFF = SEG_OFF + 8'(g);
            // One segment byte holding the attributes of two segments.
            always_ff @(posedge clk) begin
                if (!rst_n)                   seg_q[g*8 +: 8] <= 8'h00;
                else if (we && addr == MY_OFF) seg_q[g*8 +: 8] <= wdata;
            end
            assign seg_attr[(2*g)*2   +: 2] = seg_q[g*8     +: 2];
            assign seg_attr[(2*g+1)*2 +: 2] = seg_q[g*8 + 4 +: 2];
        end
    endgenerate

    // Readback multiplexer; unmapped offsets read zero.
    always_comb begin
        rdata = 8'h00;
        if (addr == HI_OFF)  rdata = hi_q;
        if (addr == CTL_OFF) rdata = ctl_q;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (addr == SEG_OFF + 8'(b)) rdata = seg_q[b*8 +: 8];
        end
    end

    assign hi_attr  = hi_q[HI_LSB +: 2];
    assign ctl_open = ctl_q[OPEN_BIT];
    assign ctl_smm  = ctl_q[SMM_BIT];
endmodule

// File: rtl/lmr_region_sel.sv
// Classifies an access address into a legacy region and picks the
// attribute that governs it. Assumes block-aligned region boundaries.
module lmr_region_sel
    import lmr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned SEG_SH     = 14,
    parameter int unsigned VIDEO_BASE = 32'hA0000,
    parameter int unsigned SEG_BASE   = 32'hC0000,
    parameter int unsigned NUM_SEG    = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [1:0]           hi_attr,
    input  logic [NUM_SEG*2-1:0] seg_attr,
    output region_e              region,
    output logic [1:0]           attr
);
    localparam int unsigned BLK_W  = ADDR_W - SEG_SH;
    localparam int unsigned SIDX_W = $clog2(NUM_SEG);
    localparam logic [BLK_W-1:0] VIDEO_BLK = BLK_W'(VIDEO_BASE >> SEG_SH);
    localparam logic [BLK_W-1:0] SEG_BLK   = BLK_W'(SEG_BASE >> SEG_SH);
    localparam logic [BLK_W-1:0] HIGH_BLK  = BLK_W'((SEG_BASE >> SEG_SH) + NUM_SEG);

    logic [BLK_W-1:0]  blk;
    logic [SIDX_W-1:0] seg_idx;
    logic [SEG_SH-1:0] offs_unused;

    assign blk         = addr[ADDR_W-1:SEG_SH];
    assign offs_unused = addr[SEG_SH-1:0];

    // Region compare chain and attribute select.
    always_comb begin
        region  = REGION_LOW;
        attr    = ATTR_OFF;
        seg_idx = '0;
        if (blk >= HIGH_BLK) begin
            region = REGION_HIGH;
            attr   = hi_attr;
        end else if (blk >= SEG_BLK) begin
            region  = REGION_SEG;
            seg_idx = SIDX_W'(blk - SEG_BLK);
            for (int s = 0; s < NUM_SEG; s++) begin
                if (seg_idx == SIDX_W'(s)) attr = seg_attr[s*2 +: 2];
            end
        end else if (blk >= VIDEO_BLK) begin
            region = REGION_VIDEO;
        end
    end
endmodule

// File: rtl/lmr_route_map.sv
// Turns region, attribute, direction and video control into a route.
// Purely combinational; no state.
module lmr_route_map
    import lmr_pkg::*;
(
    input  region_e    region,
    input  logic [1:0] attr,
    input  logic       is_write,
    input  logic       ctl_open,
    input  logic       ctl_smm,
    input  logic       smm,
    output route_e     route
);
    logic video_open;

    assign video_open = ctl_open | (smm & ctl_smm);

    // Per-region route decision.
    always_comb begin
        route = ROUTE_DRAM;
        unique case (region)
            REGION_LOW:   route = ROUTE_DRAM;
            REGION_VIDEO: route = video_open ? ROUTE_DRAM : ROUTE_FWD;
            default: begin
                unique case (attr)
                    ATTR_OFF: route = ROUTE_FWD;
                    ATTR_RO:  route = is_write ? ROUTE_DROP : ROUTE_DRAM;
                    ATTR_WO:  route = is_write ? ROUTE_DRAM : ROUTE_FWD;
                    default:  route = ROUTE_DRAM;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/lmr_decoder.sv
// Legacy memory region decoder top: register file, region classifier
// and route map. Route is combinational from the address, direction,
// mode input and registered configuration.
module lmr_decoder
    import lmr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned NUM_SEG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              smm_active,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic [1:0]        route
);
    logic [1:0]           hi_attr;
    logic [NUM_SEG*2-1:0] seg_attr;
    logic                 smram_open;
    logic                 smram_smm;
    region_e              region;
    logic [1:0]           attr;
    route_e               route_sel;

    lmr_cfg_regs #(.NUM_SEG(NUM_SEG)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .hi_attr  (hi_attr),
        .seg_attr (seg_attr),
        .ctl_open (smram_open),
        .ctl_smm  (smram_smm)
    );

    lmr_region_sel #(.ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG)) u_sel (
        .addr     (acc_addr),
        .hi_attr  (hi_attr),
        .seg_attr (seg_attr),
        .region   (region),
        .attr     (attr)
    );

    lmr_route_map u_map (
        .region   (region),
        .attr     (attr),
        .is_write (acc_write),
        .ctl_open (smram_open),
        .ctl_smm  (smram_smm),
        .smm      (smm_active),
        .route    (route_sel)
    );

    assign route = route_sel;
endmodule

// File: rtl/lmr_decoder_checker.sv
// Protocol checks for lmr_decoder, attached by bind.
module lmr_decoder_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [7:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic        smm_active,
    input logic [19:0] acc_addr,
    input logic        acc_write,
    input logic [1:0]  route,
    input logic        smram_open,
    input logic        smram_smm
);
    logic in_video;
    assign in_video = (acc_addr >= 20'hA0000) && (acc_addr <= 20'hBFFFF);

    assert_low_dram_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr < 20'hA0000) |-> (route == 2'b00));

    assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        route != 2'b11);

    assert_read_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_write |-> (route != 2'b10));

    assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 8'h72) |=>
        (smram_open == $past(cfg_wdata[6]) && smram_smm == $past(cfg_wdata[3])));

    assert_video_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_video && smram_open) |-> (route == 2'b00));

    assert_video_smm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_video && smm_active && smram_smm) |-> (route == 2'b00));
endmodule

bind lmr_decoder lmr_decoder_checker u_chk (.*);

// File: tb/lmr_decoder_bench.sv
module lmr_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        smm_active = 1'b0;
    logic [19:0] acc_addr = 20'h0;
    logic        acc_write = 1'b0;
    logic [1:0]  route;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [1:0] seg_a [12];
    logic [1:0] hi_a;

    lmr_decoder u_lmr_decoder (.*);

    always #10 clk = ~clk;

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        cfg_addr = a;
        #1;
        check(cfg_rdata, exp, req);
    endtask

    task automatic acc_chk(input logic [19:0] a, input logic w, input logic [1:0] exp, input string req);
        acc_addr = a; acc_write = w;
        #1;
        check({6'b0, route}, {6'b0, exp}, req);
    endtask

    function automatic logic [1:0] attr_route(input logic [1:0] at, input logic w);
        case (at)
            2'd0: return 2'd1;
            2'd1: return w ? 2'd2 : 2'd0;
            2'd2: return w ? 2'd0 : 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd_chk(8'h59, 8'h00, "R1");
        for (int k = 0; k < 6; k++) rd_chk(8'h5A + 8'(k), 8'h00, "R1");
        rd_chk(8'h72, 8'h02, "R1");
        // R6/R11 after reset: segments forward, low DRAM
        acc_chk(20'hC0000, 1'b0, 2'd1, "R6");
        acc_chk(20'hFFFFF, 1'b1, 2'd1, "R6");
        acc_chk(20'h9FFFF, 1'b1, 2'd0, "R11");
        acc_chk(20'h00000, 1'b0, 2'd0, "R11");
        acc_chk(20'hA0000, 1'b0, 2'd1, "R10");

        // R3/R4/R5..R8 rotated attribute sweep
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 12; i++) seg_a[i] = 2'((i + p) & 3);
            hi_a = 2'(p ^ 1);
            for (int k = 0; k < 6; k++)
                wr(8'h5A + 8'(k), {2'b11, seg_a[2*k+1], 2'b11, seg_a[2*k]});
            wr(8'h59, {2'b11, hi_a, 4'hF});
            // R12: checked in the cycle right after the last write
            acc_chk(20'hF8000, 1'b0, attr_route(hi_a, 1'b0), "R12");
            for (int i = 0; i < 12; i++) begin
                for (int w = 0; w < 2; w++) begin
                    acc_chk(20'hC0000 + 20'(i * 20'h4000), w[0], attr_route(seg_a[i], w[0]), "R4");
                    acc_chk(20'hC3FFF + 20'(i * 20'h4000), w[0], attr_route(seg_a[i], w[0]), "R4");
                end
            end
            for (int w = 0; w < 2; w++) begin
                acc_chk(20'hF0000, w[0], attr_route(hi_a, w[0]), "R3");
                acc_chk(20'hFFFFF, w[0], attr_route(hi_a, w[0]), "R3");
            end
            rd_chk(8'h59, {2'b11, hi_a, 4'hF}, "R2");
            rd_chk(8'h5D, {2'b11, seg_a[7], 2'b11, seg_a[6]}, "R2");
        end

        // R2 unmapped offsets ignored
        wr(8'h60, 8'hFF);
        wr(8'h58, 8'hFF);
        rd_chk(8'h60, 8'h00, "R2");
        rd_chk(8'h58, 8'h00, "R2");
        rd_chk(8'h59, {2'b11, hi_a, 4'hF}, "R2");
        acc_chk(20'hC0000, 1'b1, attr_route(seg_a[0], 1'b1), "R2");

        // R9/R10 video window sweep
        for (int c = 0; c < 4; c++) begin
            wr(8'h72, {1'b0, c[1], 2'b00, c[0], 3'b000});
            rd_chk(8'h72, {1'b0, c[1], 2'b00, c[0], 3'b000}, "R2");
            for (int s = 0; s < 2; s++) begin
                smm_active = s[0];
                for (int w = 0; w < 2; w++) begin
                    logic [1:0] e;
                    e = (c[1] || (s[0] && c[0])) ? 2'd0 : 2'd1;
                    acc_chk(20'hA0000, w[0], e, c[1] ? "R9" : "R10");
                    acc_chk(20'hBFFFF, w[0], e, c[1] ? "R9" : "R10");
                end
            end
            smm_active = 1'b0;
        end
        // R12: mode input takes effect without a clock edge
        wr(8'h72, 8'h08);
        acc_chk(20'hB0000, 1'b0, 2'd1, "R12");
        smm_active = 1'b1;
        acc_chk(20'hB0000, 1'b0, 2'd0, "R12");
        smm_active = 1'b0;
        acc_chk(20'hB0000, 1'b0, 2'd1, "R12");
        acc_chk(20'h9F000, 1'b1, 2'd0, "R11");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        done = 1;
        $finish;
    end
endmodule